// File: doc/BRIEF.md
# Linear Zoom Phase Generator

This block steers a linear upscaler that enlarges video by a factor between 1 and 8. It holds two independent phase accumulators. The horizontal one advances once for every output pixel. The vertical one advances once for every output line. Each accumulator adds a programmed fixed-point step, which is the input size divided by the output size, to a running fraction. The fraction gives the interpolation phase of the current output sample. A carry out of the fraction tells the surrounding datapath to move on to the next input sample or line.

The horizontal step uses 3 integer and 8 fractional bits. The vertical step uses 3 integer and 12 fractional bits. Each direction has its own programmable starting phase. That phase is reloaded on a line strobe for the horizontal side and on a frame strobe for the vertical side. A two-tap linear interpolator for one 8-bit channel uses the horizontal phase to blend a pair of neighbouring input pixels.

Each accumulator is a small state machine with two states. `ACC_IDLE` is the state after reset, and in it requests are ignored. `ACC_RUN` is the state in which requests advance the phase. The transition `start` takes either state to `ACC_RUN` and reloads the starting phase. There is no transition back to `ACC_IDLE` other than reset.

Top module: `zoom_phase_gen`

## Requirements
- R1: After reset `h_valid`, `h_adv`, `v_valid` and `v_adv` are 0, and `h_phase`, `v_phase` and `pix_out` are 0.
- R2: A start strobe (`line_start` for horizontal, `frame_start` for vertical) loads the starting phase (`h_init` or `v_init`). The first accepted request after it reports exactly that phase.
- R3: Each accepted request reports the current phase on the phase output. The accumulator then becomes (phase + step) modulo one. The advance output is 1 exactly when that addition carries past one.
- R4: Horizontal steps are 11-bit values in 3.8 format and vertical steps are 15-bit values in 3.12 format. The two directions run independently: a vertical request does not change the horizontal outputs, and a horizontal request does not change the vertical outputs.
- R5: A step value above 1.0 (above 256 horizontally, above 4096 vertically) acts as exactly 1.0.
- R6: With a step of exactly 1.0 and a starting phase of 0, every sample reports phase 0 with advance set, and `pix_out` equals `pix_a`.
- R7: Requests that arrive before the first start strobe since reset produce no valid result.
- R8: A request in the same cycle as a start strobe of the same direction is dropped. The reload takes priority.
- R9: `pix_out` = ((256 − f)·`pix_a` + f·`pix_b` + 128) >> 8, where f is the horizontal phase of that sample.
- R10: Every result appears in the cycle after the clock edge that accepted its request. Outside such cycles the valid and advance outputs are 0 and the phase outputs hold their previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_start | input | 1 | Reload the horizontal phase |
| pix_req | input | 1 | Request one output pixel |
| h_ratio | input | 11 | Horizontal step, 3.8 fixed point |
| h_init | input | 8 | Horizontal starting phase |
| pix_a | input | 8 | Left neighbour input pixel |
| pix_b | input | 8 | Right neighbour input pixel |
| frame_start | input | 1 | Reload the vertical phase |
| line_req | input | 1 | Request one output line |
| v_ratio | input | 15 | Vertical step, 3.12 fixed point |
| v_init | input | 12 | Vertical starting phase |
| h_valid | output | 1 | Horizontal result present |
| h_adv | output | 1 | Advance to next input pixel |
| h_phase | output | 8 | Phase of this output pixel |
| pix_out | output | 8 | Interpolated pixel |
| v_valid | output | 1 | Vertical result present |
| v_adv | output | 1 | Advance to next input line |
| v_phase | output | 12 | Phase of this output line |

## Verification
Every output of the block is registered once, so each result is due exactly one cycle after the edge that sampled its request or strobe. This holds for the phase, the advance flag and the interpolated pixel alike. The driver sets the inputs half a period before an edge. It pushes the expected outputs for that edge into a queue. The monitor pops that entry a quarter period after the same edge, when all registers have settled and the inputs have not yet changed. The reference model in the bench recomputes phase, carry and blend from the requirement formulas for every cycle, including idle cycles, where it expects valid and advance to be 0.

// File: rtl/zoom_pkg.sv
package zoom_pkg;
    localparam int H_INT_W  = 3;
    localparam int H_FRAC_W = 8;
    localparam int V_INT_W  = 3;
    localparam int V_FRAC_W = 12;
    localparam int PIX_W    = 8;

    typedef enum logic {
        ACC_IDLE = 1'b0,
        ACC_RUN  = 1'b1
    } acc_state_t;
endpackage

// File: rtl/zoom_phase_acc.sv
module zoom_phase_acc
    import zoom_pkg::*;
#(
    parameter int INT_W  = 3,
    parameter int FRAC_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    req_i,
    input  logic [INT_W+FRAC_W-1:0] ratio_i,
    input  logic [FRAC_W-1:0]       init_i,
    output logic                    take_o,
    output logic [FRAC_W-1:0]       cur_phase_o,
    output logic                    valid_o,
    output logic                    adv_o,
    output logic [FRAC_W-1:0]       phase_o
);
    localparam int RW = INT_W + FRAC_W;
    localparam logic [RW-1:0] ONE = {{(RW-1){1'b0}}, 1'b1} << FRAC_W;

    acc_state_t          state_q, state_d;
    logic [FRAC_W-1:0]   acc_q;
    logic [FRAC_W:0]     step;
    logic [FRAC_W:0]     sum;
    logic                take;

    // step clamp: anything above unity behaves as unity
    always_comb begin
        if (ratio_i > ONE) step = ONE[FRAC_W:0];
        else               step = ratio_i[FRAC_W:0];
        sum  = {1'b0, acc_q} + step;
        take = req_i && !start_i && (state_q == ACC_RUN);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: if (start_i) state_d = ACC_RUN;
            ACC_RUN:  state_d = ACC_RUN;
            default:  state_d = ACC_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    // accumulator and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            valid_o <= 1'b0;
            adv_o   <= 1'b0;
            phase_o <= '0;
        end else begin
            if (start_i)   acc_q <= init_i;
            else if (take) acc_q <= sum[FRAC_W-1:0];
            valid_o <= take;
            adv_o   <= take && sum[FRAC_W];
            if (take) phase_o <= acc_q;
        end
    end

    assign take_o      = take;
    assign cur_phase_o = acc_q;

    // R3: advance only accompanies a result
    assert_adv_with_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adv_o |-> valid_o);
    // R10: a result follows a request by one cycle
    assert_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(req_i));
    // R7: nothing comes out of the idle state
    assert_idle_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACC_IDLE) |=> !valid_o);
    // R8: a reload drops a simultaneous request
    assert_start_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !valid_o);
    // R10: phase holds between results
    assert_phase_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(phase_o));
endmodule

// File: rtl/zoom_lerp.sv
module zoom_lerp #(
    parameter int W  = 8,
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [FW-1:0] frac_i,
    input  logic [W-1:0]  p0_i,
    input  logic [W-1:0]  p1_i,
    output logic [W-1:0]  out_o
);
    localparam int SW = W + FW;
    localparam logic [SW-1:0] HALF = {{(SW-1){1'b0}}, 1'b1} << (FW - 1);

    logic [FW:0]   w0;
    logic [SW-1:0] blend;

    always_comb begin
        w0    = {1'b1, {FW{1'b0}}} - {1'b0, frac_i};
        blend = SW'(w0) * SW'(p0_i) + SW'(frac_i) * SW'(p1_i) + HALF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    out_o <= '0;
        else if (en_i) out_o <= W'(blend >> FW);
    end

    // R6: zero phase passes the left pixel through unchanged
    assert_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_i) && ($past(frac_i) == '0)) |-> (out_o == $past(p0_i)));
    // R9: the result lies between the two neighbours
    assert_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_i) |-> ((out_o >= (($past(p0_i) < $past(p1_i)) ? $past(p0_i) : $past(p1_i))) &&
                         (out_o <= (($past(p0_i) > $past(p1_i)) ? $past(p0_i) : $past(p1_i)))));
endmodule

// File: rtl/zoom_phase_gen.sv
module zoom_phase_gen
    import zoom_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          line_start,
    input  logic                          pix_req,
    input  logic [H_INT_W+H_FRAC_W-1:0]   h_ratio,
    input  logic [H_FRAC_W-1:0]           h_init,
    input  logic [PIX_W-1:0]              pix_a,
    input  logic [PIX_W-1:0]              pix_b,
    input  logic                          frame_start,
    input  logic                          line_req,
    input  logic [V_INT_W+V_FRAC_W-1:0]   v_ratio,
    input  logic [V_FRAC_W-1:0]           v_init,
    output logic                          h_valid,
    output logic                          h_adv,
    output logic [H_FRAC_W-1:0]           h_phase,
    output logic [PIX_W-1:0]              pix_out,
    output logic                          v_valid,
    output logic                          v_adv,
    output logic [V_FRAC_W-1:0]           v_phase
);
    logic                h_take;
    logic [H_FRAC_W-1:0] h_cur;
    logic                v_take;
    logic [V_FRAC_W-1:0] v_cur;

    zoom_phase_acc #(.INT_W(H_INT_W), .FRAC_W(H_FRAC_W)) u_hacc (
        .clk(clk), .rst_n(rst_n), .start_i(line_start), .req_i(pix_req),
        .ratio_i(h_ratio), .init_i(h_init), .take_o(h_take), .cur_phase_o(h_cur),
        .valid_o(h_valid), .adv_o(h_adv), .phase_o(h_phase));

    zoom_phase_acc #(.INT_W(V_INT_W), .FRAC_W(V_FRAC_W)) u_vacc (
        .clk(clk), .rst_n(rst_n), .start_i(frame_start), .req_i(line_req),
        .ratio_i(v_ratio), .init_i(v_init), .take_o(v_take), .cur_phase_o(v_cur),
        .valid_o(v_valid), .adv_o(v_adv), .phase_o(v_phase));

    zoom_lerp #(.W(PIX_W), .FW(H_FRAC_W)) u_lerp (
        .clk(clk), .rst_n(rst_n), .en_i(h_take), .frac_i(h_cur),
        .p0_i(pix_a), .p1_i(pix_b), .out_o(pix_out));

    // R4: vertical activity alone leaves the horizontal side idle
    assert_indep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_req && line_req) |=> !h_valid);
    // R9: the pixel result tracks the horizontal phase
    assert_pix_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !h_valid |-> $stable(pix_out));
endmodule

// File: tb/test_zoom_phase_gen.sv
module test_zoom_phase_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 0, pix_req = 0, frame_start = 0, line_req = 0;
    logic [10:0] h_ratio = '0;
    logic [7:0]  h_init = '0, pix_a = '0, pix_b = '0;
    logic [14:0] v_ratio = '0;
    logic [11:0] v_init = '0;
    logic        h_valid, h_adv, v_valid, v_adv;
    logic [7:0]  h_phase, pix_out;
    logic [11:0] v_phase;

    int total = 0;
    int bad = 0;
    string tag = "R3";

    always #10 clk = ~clk;

    zoom_phase_gen i_zoom_phase_gen (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .pix_req(pix_req),
        .h_ratio(h_ratio), .h_init(h_init), .pix_a(pix_a), .pix_b(pix_b),
        .frame_start(frame_start), .line_req(line_req), .v_ratio(v_ratio),
        .v_init(v_init), .h_valid(h_valid), .h_adv(h_adv), .h_phase(h_phase),
        .pix_out(pix_out), .v_valid(v_valid), .v_adv(v_adv), .v_phase(v_phase));

    typedef struct {
        string      t;
        logic       hv, ha, vv, va;
        logic [7:0] hp, px;
        logic [11:0] vp;
    } exp_t;

    exp_t q[$];

    // reference model state
    logic        m_hrun = 0, m_vrun = 0;
    logic [7:0]  m_hacc = 0, m_hph = 0, m_px = 0;
    logic [11:0] m_vacc = 0, m_vph = 0;

    task automatic check(string t, string what, int act, int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, expv);
        end
    endtask

    // drive one cycle and queue its expected result
    task automatic cyc(logic ls, logic pr, logic fs, logic lr, logic [7:0] a, logic [7:0] b);
        exp_t e;
        int hs, vs, s;
        line_start = ls; pix_req = pr; frame_start = fs; line_req = lr;
        pix_a = a; pix_b = b;
        hs = (h_ratio > 256) ? 256 : int'(h_ratio);
        vs = (v_ratio > 4096) ? 4096 : int'(v_ratio);
        e.t = tag; e.hv = 0; e.ha = 0; e.vv = 0; e.va = 0;
        if (ls) begin m_hacc = h_init; m_hrun = 1; end
        else if (pr && m_hrun) begin
            s = int'(m_hacc) + hs;
            e.hv = 1; e.ha = (s >= 256);
            m_hph = m_hacc;
            m_px = 8'(((256 - int'(m_hacc)) * int'(a) + int'(m_hacc) * int'(b) + 128) >> 8);
            m_hacc = 8'(s);
        end
        if (fs) begin m_vacc = v_init; m_vrun = 1; end
        else if (lr && m_vrun) begin
            s = int'(m_vacc) + vs;
            e.vv = 1; e.va = (s >= 4096);
            m_vph = m_vacc;
            m_vacc = 12'(s);
        end
        e.hp = m_hph; e.px = m_px; e.vp = m_vph;
        q.push_back(e);
        @(negedge clk);
    endtask

    // monitor: sample a quarter period after each edge
    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.t, "h_valid", h_valid, e.hv);
            check(e.t, "h_adv",   h_adv,   e.ha);
            check(e.t, "h_phase", h_phase, e.hp);
            check(e.t, "pix_out", pix_out, e.px);
            check(e.t, "v_valid", v_valid, e.vv);
            check(e.t, "v_adv",   v_adv,   e.va);
            check(e.t, "v_phase", v_phase, e.vp);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "h_valid", h_valid, 0);
        check("R1", "v_valid", v_valid, 0);
        check("R1", "h_adv", h_adv, 0);
        check("R1", "v_adv", v_adv, 0);
        check("R1", "h_phase", h_phase, 0);
        check("R1", "v_phase", v_phase, 0);
        check("R1", "pix_out", pix_out, 0);
        rst_n = 1;
        @(negedge clk);

        // R7: requests before any start are dropped
        tag = "R7";
        h_ratio = 11'd96; h_init = 8'd32; v_ratio = 15'd1365; v_init = 12'd100;
        for (int k = 0; k < 3; k++) cyc(0, 1, 0, 1, 8'd10, 8'd20);

        // R2 and R8: start with a simultaneous request
        tag = "R8";
        cyc(1, 1, 1, 1, 8'd10, 8'd20);
        tag = "R2";
        cyc(0, 1, 0, 1, 8'd40, 8'd200);

        // R3 and R9: fractional step over many samples
        tag = "R3";
        for (int k = 0; k < 20; k++) cyc(0, 1, 0, 1, 8'(k * 37), 8'(k * 91 + 5));
        tag = "R9";
        for (int k = 0; k < 12; k++) cyc(0, (k % 3) != 2, 0, 0, 8'(255 - k * 13), 8'(k * 19));

        // R10: gaps leave outputs held and valid low
        tag = "R10";
        for (int k = 0; k < 4; k++) cyc(0, k[0], 0, 0, 8'd7, 8'd9);

        // R4: one direction alone
        tag = "R4";
        for (int k = 0; k < 5; k++) cyc(0, 0, 0, 1, 8'd1, 8'd2);
        for (int k = 0; k < 5; k++) cyc(0, 1, 0, 0, 8'd3, 8'd250);

        // R5: steps above unity clamp
        tag = "R5";
        h_ratio = 11'h2C0; v_ratio = 15'h5A00; h_init = 8'd77; v_init = 12'd999;
        cyc(1, 0, 1, 0, 8'd0, 8'd0);
        for (int k = 0; k < 6; k++) cyc(0, 1, 0, 1, 8'(k * 41), 8'(k * 11));

        // R6: exact unity with zero phase is a bypass
        tag = "R6";
        h_ratio = 11'd256; v_ratio = 15'd4096; h_init = 8'd0; v_init = 12'd0;
        cyc(1, 0, 1, 0, 8'd0, 8'd0);
        for (int k = 0; k < 8; k++) cyc(0, 1, 0, 1, 8'(k * 29 + 3), 8'(200 - k));

        // R2: mid-line reload restarts the phase
        tag = "R2";
        h_ratio = 11'd200; h_init = 8'd150; v_ratio = 15'd700; v_init = 12'd4000;
        cyc(1, 0, 1, 0, 8'd0, 8'd0);
        for (int k = 0; k < 6; k++) cyc(0, 1, 0, 1, 8'(k * 50), 8'(255 - k * 40));

        tag = "R10";
        cyc(0, 0, 0, 0, 8'd0, 8'd0);
        cyc(0, 0, 0, 0, 8'd0, 8'd0);
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule